// File: doc/BRIEF.md
# Vector Lane Permute and Extract Unit

This unit rearranges the lanes of a wide vector operand. It takes a source vector of `LANES` elements, each `ELEM_W` bits wide (16 lanes of 32 bits by default), and works in one of two modes chosen by a six-bit operation code.

In shuffle mode it builds a new vector. Each output lane is filled from the source lane named by the same-numbered lane of an index vector. All output lanes are worked out in parallel. In extract mode it returns one source lane as a scalar. The lane number comes either from a scalar index operand or from the instruction immediate, chosen by a select bit.

Only the low `log2(LANES)` bits of any index are used, so index values wrap around the lane count. The operation is decoded and computed without a clock. The result is captured in one output register stage, so it appears on the cycle after the operation is presented. An operation code the unit does not know gives zero data and raises an error flag.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `resValid`, `resErr`, `resVec` and `resScalar` are all zero.
- R2: `resValid` equals the value `opValid` had on the previous clock edge, so every result has exactly one cycle of latency.
- R3: With `opValid` high and `opCode` = 24 (shuffle), lane i of `resVec` (bits i*32+31 down to i*32) on the next cycle equals the source lane whose number is held in the low 4 bits of lane i of `idxVec`, for every i from 0 to 15.
- R4: Index bits above bit 3 are ignored in every form: in the index vector lanes, in `idxScalar` and in `idxImm`. For example, index 37 selects lane 5.
- R5: With `opValid` high, `opCode` = 25 (extract) and `useImm` = 0, `resScalar` on the next cycle equals the source lane selected by `idxScalar[3:0]`.
- R6: With `opValid` high, `opCode` = 25 and `useImm` = 1, `resScalar` on the next cycle equals the source lane selected by `idxImm[3:0]`, and `idxScalar` has no effect.
- R7: A shuffle result has `resScalar` = 0. An extract result has `resVec` = 0. Neither of them raises `resErr`.
- R8: With `opValid` high and any `opCode` other than 24 or 25, the next cycle shows `resErr` = 1 with `resVec` = 0 and `resScalar` = 0.
- R9: A cycle with `opValid` low gives `resErr` = 0, `resVec` = 0 and `resScalar` = 0 on the next cycle, whatever the other inputs hold.
- R10: In shuffle mode `useImm` and `idxImm` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register is updated on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 6 | Operation code: 24 is shuffle, 25 is extract |
| useImm | input | 1 | Extract only: take the lane index from `idxImm` instead of `idxScalar` |
| srcVec | input | LANES*ELEM_W (512) | Source vector; lane i sits at bits i*ELEM_W and up |
| idxVec | input | LANES*ELEM_W (512) | Index vector for shuffle, one index per lane |
| idxScalar | input | ELEM_W (32) | Scalar lane index for extract |
| idxImm | input | IMM_W (9) | Immediate lane index for extract |
| resValid | output | 1 | A result is present this cycle |
| resVec | output | LANES*ELEM_W (512) | Shuffled vector |
| resScalar | output | ELEM_W (32) | Extracted lane |
| resErr | output | 1 | The operation code was not recognised |

## Verification
The bench builds the unit with its defaults: 16 lanes of 32 bits and a 9-bit immediate. With these values the lane index is 4 bits wide. Every index source can therefore carry bits above the lane range, both in the upper 28 bits of an index lane or scalar and in the upper 5 bits of the immediate. This makes the wrap of R4 reachable in all three index paths. A source vector whose lanes all hold distinct values lets each of the 16 selections be told apart, so a wrong mux leg shows up in the data itself.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_SHUFFLE = 6'd24;
  localparam logic [OP_W-1:0] OP_EXTRACT = 6'd25;

  typedef struct packed {
    logic doShuffle;
    logic doExtract;
    logic pickImm;
    logic badOp;
  } vperm_strobe_t;

endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  input  logic            useImm,
  output vperm_strobe_t   strobes
);

  always_comb begin
    strobes = '0;
    if (opValid) begin
      unique case (opCode)
        OP_SHUFFLE: strobes.doShuffle = 1'b1;
        OP_EXTRACT: begin
          strobes.doExtract = 1'b1;
          strobes.pickImm   = useImm;
        end
        default:    strobes.badOp = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/vperm_lane_sel.sv
module vperm_lane_sel #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES*ELEM_W-1:0] srcFlat,
  input  logic [IDX_W-1:0]        sel,
  output logic [ELEM_W-1:0]       elem
);

  logic [ELEM_W-1:0] laneArr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign laneArr[g] = srcFlat[g*ELEM_W +: ELEM_W];
  end

  always_comb elem = laneArr[sel];

endmodule

// File: rtl/vperm_dpath.sv
module vperm_dpath
  import vperm_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  parameter int IMM_W  = 9,
  localparam int IDX_W = $clog2(LANES),
  localparam int VEC_W = LANES * ELEM_W
) (
  input  vperm_strobe_t     strobes,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [VEC_W-1:0]  idxVec,
  input  logic [ELEM_W-1:0] idxScalar,
  input  logic [IMM_W-1:0]  idxImm,
  output logic [VEC_W-1:0]  shufVec,
  output logic [ELEM_W-1:0] extElem
);

  logic [VEC_W-1:0]  rawShuf;
  logic [IDX_W-1:0]  extSel;
  logic [ELEM_W-1:0] rawExt;

  // one independent lane selector per output lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vperm_lane_sel #(.LANES(LANES), .ELEM_W(ELEM_W)) sel_i (
      .srcFlat (srcVec),
      .sel     (idxVec[i*ELEM_W +: IDX_W]),
      .elem    (rawShuf[i*ELEM_W +: ELEM_W])
    );
  end

  always_comb extSel = strobes.pickImm ? idxImm[IDX_W-1:0] : idxScalar[IDX_W-1:0];

  vperm_lane_sel #(.LANES(LANES), .ELEM_W(ELEM_W)) ext_i (
    .srcFlat (srcVec),
    .sel     (extSel),
    .elem    (rawExt)
  );

  always_comb begin
    shufVec = strobes.doShuffle ? rawShuf : '0;
    extElem = strobes.doExtract ? rawExt  : '0;
  end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  parameter int IMM_W  = 9,
  localparam int VEC_W = LANES * ELEM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              useImm,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [VEC_W-1:0]  idxVec,
  input  logic [ELEM_W-1:0] idxScalar,
  input  logic [IMM_W-1:0]  idxImm,
  output logic              resValid,
  output logic [VEC_W-1:0]  resVec,
  output logic [ELEM_W-1:0] resScalar,
  output logic              resErr
);

  vperm_strobe_t     strobes;
  logic [VEC_W-1:0]  shufVec;
  logic [ELEM_W-1:0] extElem;

  vperm_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .useImm  (useImm),
    .strobes (strobes)
  );

  vperm_dpath #(.LANES(LANES), .ELEM_W(ELEM_W), .IMM_W(IMM_W)) dpath_i (
    .strobes   (strobes),
    .srcVec    (srcVec),
    .idxVec    (idxVec),
    .idxScalar (idxScalar),
    .idxImm    (idxImm),
    .shufVec   (shufVec),
    .extElem   (extElem)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resVec    <= '0;
      resScalar <= '0;
      resErr    <= 1'b0;
    end else begin
      resValid  <= opValid;
      resVec    <= shufVec;
      resScalar <= extElem;
      resErr    <= strobes.badOp;
    end
  end

endmodule

// File: rtl/vperm_chk.sv
module vperm_chk
  import vperm_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  parameter int IMM_W  = 9,
  localparam int IDX_W = $clog2(LANES),
  localparam int VEC_W = LANES * ELEM_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic              useImm,
  input logic [VEC_W-1:0]  srcVec,
  input logic [VEC_W-1:0]  idxVec,
  input logic [ELEM_W-1:0] idxScalar,
  input logic [IMM_W-1:0]  idxImm,
  input logic              resValid,
  input logic [VEC_W-1:0]  resVec,
  input logic [ELEM_W-1:0] resScalar,
  input logic              resErr
);

  logic [ELEM_W-1:0] srcArr [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_arr
    assign srcArr[g] = srcVec[g*ELEM_W +: ELEM_W];
  end

  logic [ELEM_W-1:0] wantLane0, wantByReg, wantByImm;
  always_comb begin
    wantLane0 = srcArr[idxVec[IDX_W-1:0]];
    wantByReg = srcArr[idxScalar[IDX_W-1:0]];
    wantByImm = srcArr[idxImm[IDX_W-1:0]];
  end

  logic isShuf, isExt, isBad;
  always_comb begin
    isShuf = opValid && (opCode == OP_SHUFFLE);
    isExt  = opValid && (opCode == OP_EXTRACT);
    isBad  = opValid && !isShuf && !isExt;
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);

  // R3
  shuf_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    isShuf |=> resVec[ELEM_W-1:0] == $past(wantLane0));

  // R5
  ext_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isExt && !useImm) |=> resScalar == $past(wantByReg));

  // R6
  ext_imm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isExt && useImm) |=> resScalar == $past(wantByImm));

  // R7
  shuf_scalar_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    isShuf |=> (resScalar == '0) && !resErr);

  // R7
  ext_vec_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    isExt |=> (resVec == '0) && !resErr);

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    isBad |=> resErr && (resVec == '0) && (resScalar == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resErr && (resVec == '0) && (resScalar == '0));

endmodule

bind vperm_unit vperm_chk #(.LANES(LANES), .ELEM_W(ELEM_W), .IMM_W(IMM_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .useImm    (useImm),
  .srcVec    (srcVec),
  .idxVec    (idxVec),
  .idxScalar (idxScalar),
  .idxImm    (idxImm),
  .resValid  (resValid),
  .resVec    (resVec),
  .resScalar (resScalar),
  .resErr    (resErr)
);

// File: tb/vperm_unit_tb_top.sv
module vperm_unit_tb_top;

  localparam int LANES  = 16;
  localparam int ELEM_W = 32;
  localparam int IMM_W  = 9;
  localparam int VEC_W  = LANES * ELEM_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [5:0]        opCode = '0;
  logic              useImm = 1'b0;
  logic [VEC_W-1:0]  srcVec = '0;
  logic [VEC_W-1:0]  idxVec = '0;
  logic [ELEM_W-1:0] idxScalar = '0;
  logic [IMM_W-1:0]  idxImm = '0;
  logic              resValid;
  logic [VEC_W-1:0]  resVec;
  logic [ELEM_W-1:0] resScalar;
  logic              resErr;

  always #2 clk = ~clk;

  vperm_unit #(.LANES(LANES), .ELEM_W(ELEM_W), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .useImm(useImm),
    .srcVec(srcVec), .idxVec(idxVec), .idxScalar(idxScalar), .idxImm(idxImm),
    .resValid(resValid), .resVec(resVec), .resScalar(resScalar), .resErr(resErr)
  );

  typedef struct {
    logic              vld;
    logic [VEC_W-1:0]  vec;
    logic [ELEM_W-1:0] scal;
    logic              err;
    int                due;
    string             req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   failures = 0;
  int   cycle = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cycle++;

  function automatic logic [31:0] nextRand(inout logic [31:0] s);
    s = s * 32'd1664525 + 32'd1013904223;
    return s;
  endfunction

  function automatic logic [ELEM_W-1:0] laneOf(logic [VEC_W-1:0] v, int n);
    return v[(n % LANES)*ELEM_W +: ELEM_W];
  endfunction

  task automatic issue(input logic ov, input logic [5:0] op, input logic ui,
                       input logic [VEC_W-1:0] sv, input logic [VEC_W-1:0] iv,
                       input logic [ELEM_W-1:0] is, input logic [IMM_W-1:0] im,
                       input string req);
    exp_t e;
    @(negedge clk);
    opValid = ov; opCode = op; useImm = ui;
    srcVec = sv; idxVec = iv; idxScalar = is; idxImm = im;
    e.vld = ov; e.vec = '0; e.scal = '0; e.err = 1'b0;
    e.due = cycle + 1; e.req = req;
    if (ov) begin
      if (op == 6'd24) begin
        for (int i = 0; i < LANES; i++)
          e.vec[i*ELEM_W +: ELEM_W] = laneOf(sv, int'(iv[i*ELEM_W +: 4]));
      end else if (op == 6'd25) begin
        e.scal = ui ? laneOf(sv, int'(im[3:0])) : laneOf(sv, int'(is[3:0]));
      end else begin
        e.err = 1'b1;
      end
    end
    expQ.push_back(e);
  endtask

  // monitor: compare results in the cycle they are due
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == cycle) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (resValid !== e.vld || resVec !== e.vec || resScalar !== e.scal || resErr !== e.err) begin
        failures++;
        $display("FAIL %s: got vld=%0b err=%0b scal=%h vec=%h ; exp vld=%0b err=%0b scal=%h vec=%h",
                 e.req, resValid, resErr, resScalar, resVec, e.vld, e.err, e.scal, e.vec);
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog: got no completion, exp completion");
    finishRun();
  end

  initial begin
    logic [VEC_W-1:0] src, idx;
    for (int i = 0; i < LANES; i++) src[i*ELEM_W +: ELEM_W] = 32'hA000_0000 + 32'(i * 17 + 3);

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resErr !== 1'b0 || resVec !== '0 || resScalar !== '0) begin
      failures++;
      $display("FAIL R1 reset: got vld=%0b err=%0b scal=%h, exp all zero", resValid, resErr, resScalar);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resErr !== 1'b0 || resVec !== '0 || resScalar !== '0) begin
      failures++;
      $display("FAIL R1 after release: got vld=%0b err=%0b, exp 0 0", resValid, resErr);
    end

    // R9: idle with busy inputs
    issue(1'b0, 6'd24, 1'b0, src, src, 32'd3, 9'd4, "R9 idle shuffle code");
    issue(1'b0, 6'd63, 1'b1, src, src, 32'd3, 9'd4, "R9 idle bad code");

    // R3: identity, reverse, broadcast
    for (int i = 0; i < LANES; i++) idx[i*ELEM_W +: ELEM_W] = 32'(i);
    issue(1'b1, 6'd24, 1'b0, src, idx, '0, '0, "R3 identity shuffle");
    for (int i = 0; i < LANES; i++) idx[i*ELEM_W +: ELEM_W] = 32'(LANES - 1 - i);
    issue(1'b1, 6'd24, 1'b0, src, idx, '0, '0, "R3 reverse shuffle");
    for (int i = 0; i < LANES; i++) idx[i*ELEM_W +: ELEM_W] = 32'd9;
    issue(1'b1, 6'd24, 1'b0, src, idx, '0, '0, "R3 broadcast lane 9");
    // R4: upper index bits set
    for (int i = 0; i < LANES; i++) idx[i*ELEM_W +: ELEM_W] = 32'hABCD_0000 + 32'(i * 16 + ((i * 5) % LANES));
    issue(1'b1, 6'd24, 1'b0, src, idx, '0, '0, "R4 shuffle wrap");
    // R10: immediate controls ignored in shuffle
    for (int i = 0; i < LANES; i++) idx[i*ELEM_W +: ELEM_W] = 32'((i + 3) % LANES);
    issue(1'b1, 6'd24, 1'b1, src, idx, 32'd7, 9'd5, "R10 shuffle useImm=1");
    issue(1'b1, 6'd24, 1'b0, src, idx, 32'd1, 9'h1FF, "R10 shuffle imm all ones");

    // R5: register index extract, R7 vector zero
    issue(1'b1, 6'd25, 1'b0, src, idx, 32'd0, 9'd11, "R5 extract lane 0");
    issue(1'b1, 6'd25, 1'b0, src, idx, 32'd15, 9'd2, "R5 R7 extract lane 15");
    issue(1'b1, 6'd25, 1'b0, src, idx, 32'd37, 9'd0, "R4 extract index 37");
    issue(1'b1, 6'd25, 1'b0, src, idx, 32'hFFFF_FFF5, 9'd0, "R4 extract high scalar bits");
    // R6: immediate index
    issue(1'b1, 6'd25, 1'b1, src, idx, 32'd2, 9'd7, "R6 extract imm 7");
    issue(1'b1, 6'd25, 1'b1, src, idx, 32'd12, 9'h1F3, "R4 R6 extract imm wrap");

    // R8: unknown codes
    issue(1'b1, 6'd0, 1'b0, src, idx, 32'd1, 9'd1, "R8 code 0");
    issue(1'b1, 6'd23, 1'b0, src, idx, 32'd1, 9'd1, "R8 code 23");
    issue(1'b1, 6'd26, 1'b1, src, idx, 32'd1, 9'd1, "R8 code 26");
    issue(1'b1, 6'd63, 1'b0, src, idx, 32'd1, 9'd1, "R8 code 63");
    issue(1'b0, 6'd0, 1'b0, src, idx, 32'd1, 9'd1, "R9 idle after error");

    // back-to-back mixed traffic
    for (int n = 0; n < 40; n++) begin
      logic [VEC_W-1:0] rs, ri;
      logic [31:0] r;
      for (int i = 0; i < LANES; i++) begin
        rs[i*ELEM_W +: ELEM_W] = nextRand(seed);
        ri[i*ELEM_W +: ELEM_W] = nextRand(seed);
      end
      r = nextRand(seed);
      case (r[1:0])
        2'd0: issue(1'b1, 6'd24, r[8], rs, ri, nextRand(seed), r[20:12], "R3 R7 mixed shuffle");
        2'd1: issue(1'b1, 6'd25, 1'b0, rs, ri, nextRand(seed), r[20:12], "R5 R7 mixed extract");
        2'd2: issue(1'b1, 6'd25, 1'b1, rs, ri, nextRand(seed), r[20:12], "R6 mixed imm extract");
        default: issue(r[4], r[29:24], r[8], rs, ri, nextRand(seed), r[20:12], "R2 R8 mixed any");
      endcase
    end

    issue(1'b0, 6'd0, 1'b0, '0, '0, '0, '0, "R2 drain");
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 pending results: got %0d left, exp 0", expQ.size());
    end
    finishRun();
  end

endmodule